// File: doc/BRIEF.md
# Processor Bus-Hold Request Arbiter

This block sits on the processor side of a shared system bus. It decides when the core hands its address, data and control buses to an external bus master, such as a block-transfer engine, and when it takes them back. A request from the external master is looked at only at the end of a core bus cycle, so a cycle already in flight always completes. Once the request is taken, the arbiter stalls the execution unit and turns off the bus drivers. One clock later it raises the grant. The grant stays up for as long as the request is held. One clock after the request is dropped, the grant falls and the drivers come back on in that same cycle.

Interrupt requests rank below bus requests, and reset ranks above both. An interrupt is accepted only at an instruction boundary, while the core owns the bus and no bus request is present. Reset clears any hold at once: the grant and the stall drop in the same cycle that reset is high.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While rst_i is high, bus_grant_o is 0, exec_stall_o is 0, irq_accept_o is 0 and all bits of bus_oe_o are 1, in that same cycle and from any prior state.
- R2: A bus request is taken only at a clock edge where both bus_req_i and cycle_end_i are 1. With cycle_end_i at 0, bus_oe_o stays all ones.
- R3: After a clock edge that takes a bus request, bus_oe_o is all zeros, exec_stall_o is 1 and bus_grant_o is still 0.
- R4: bus_grant_o rises exactly one clock after bus_oe_o goes to all zeros. This holds even if bus_req_i is dropped during that release cycle.
- R5: While granted, bus_grant_o and exec_stall_o stay 1 for every clock edge at which bus_req_i is sampled high.
- R6: One clock after bus_req_i is sampled low while granted, bus_grant_o is 0, exec_stall_o is 0 and bus_oe_o is all ones, all in the same cycle.
- R7: irq_accept_o is 1 exactly when intr_i and insn_end_i are both 1, bus_req_i is 0, rst_i is 0 and the core owns the bus (bus_oe_o all ones).
- R8: irq_accept_o is 0 while a bus request is pending (bus_req_i high) or while the bus is released or granted, even with intr_i and insn_end_i high.
- R9: bus_grant_o is never 1 while any bit of bus_oe_o is 1.
- R10: The three bits of bus_oe_o (bit 0 address, bit 1 data, bit 2 control) always carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset; highest-priority request |
| bus_req_i | input | 1 | Bus request from the external master |
| cycle_end_i | input | 1 | Core signals the last clock of its current bus cycle |
| intr_i | input | 1 | Interrupt request |
| insn_end_i | input | 1 | Core is at an instruction boundary |
| bus_grant_o | output | 1 | Bus granted; the drivers are already off |
| exec_stall_o | output | 1 | Stall to the execution unit |
| irq_accept_o | output | 1 | Interrupt accepted this cycle |
| bus_oe_o | output | 3 | Driver enables: bit 0 address, bit 1 data, bit 2 control |

## Verification
The assertions assume that rst_i is high at the first clock edge. They also assume that every input changes only away from the rising edge, so each sampled value is stable. The bench drives all inputs on the falling edge and holds reset across the first edges. The assertions place no limits on how bus_req_i, cycle_end_i, intr_i and insn_end_i combine. For that reason the stimulus includes requests that arrive mid-cycle, requests dropped during the release cycle, and reset asserted in the middle of a grant.

// File: rtl/bha_pkg.sv
package bha_pkg;

    localparam int BUS_GROUPS = 3;   // address, data, control

    typedef enum logic [1:0] {
        ST_OWN   = 2'd0,   // core owns and drives the buses
        ST_FLOAT = 2'd1,   // drivers off, grant not yet given
        ST_GRANT = 2'd2    // external master holds the buses
    } hold_state_e;

    typedef struct packed {
        logic grant;
        logic stall;
        logic drive;
    } hold_view_t;

    function automatic hold_view_t decode_state(hold_state_e st, logic rst);
        hold_view_t v;
        v.grant = (st == ST_GRANT) && !rst;
        v.stall = (st != ST_OWN) && !rst;
        v.drive = (st == ST_OWN) || rst;
        return v;
    endfunction

endpackage

// File: rtl/bha_hold_fsm.sv
module bha_hold_fsm
    import bha_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        req_i,
    input  logic        cycle_end_i,
    output hold_state_e state_o
);
    hold_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OWN:   if (req_i && cycle_end_i) state_d = ST_FLOAT;
            ST_FLOAT: state_d = ST_GRANT;
            ST_GRANT: if (!req_i) state_d = ST_OWN;
            default:  state_d = ST_OWN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_OWN;
        else       state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/bha_irq_gate.sv
module bha_irq_gate (
    input  logic rst_i,
    input  logic req_i,
    input  logic owned_i,
    input  logic intr_i,
    input  logic insn_end_i,
    output logic accept_o
);
    // priority: reset, then bus request, then interrupt
    always_comb begin
        if (rst_i)        accept_o = 1'b0;
        else if (req_i)   accept_o = 1'b0;
        else if (!owned_i) accept_o = 1'b0;
        else              accept_o = intr_i && insn_end_i;
    end
endmodule

// File: rtl/bha_drive_fanout.sv
module bha_drive_fanout #(
    parameter int GROUPS = 3
) (
    input  logic              drive_i,
    output logic [GROUPS-1:0] oe_o
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign oe_o[g] = drive_i;
    end
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
    import bha_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  bus_req_i,
    input  logic                  cycle_end_i,
    input  logic                  intr_i,
    input  logic                  insn_end_i,
    output logic                  bus_grant_o,
    output logic                  exec_stall_o,
    output logic                  irq_accept_o,
    output logic [BUS_GROUPS-1:0] bus_oe_o
);
    hold_state_e state;
    hold_view_t  view;

    bha_hold_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .req_i       (bus_req_i),
        .cycle_end_i (cycle_end_i),
        .state_o     (state)
    );

    assign view = decode_state(state, rst_i);

    bha_irq_gate u_irq (
        .rst_i      (rst_i),
        .req_i      (bus_req_i),
        .owned_i    (view.drive),
        .intr_i     (intr_i),
        .insn_end_i (insn_end_i),
        .accept_o   (irq_accept_o)
    );

    bha_drive_fanout #(.GROUPS(BUS_GROUPS)) u_oe (
        .drive_i (view.drive),
        .oe_o    (bus_oe_o)
    );

    assign bus_grant_o  = view.grant;
    assign exec_stall_o = view.stall;
endmodule

module bus_hold_arbiter_chk #(
    parameter int GROUPS = 3
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              bus_req_i,
    input logic              cycle_end_i,
    input logic              bus_grant_o,
    input logic              exec_stall_o,
    input logic              irq_accept_o,
    input logic [GROUPS-1:0] bus_oe_o
);
    localparam logic [GROUPS-1:0] ALL_ON = '1;

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |-> (!bus_grant_o && !exec_stall_o && !irq_accept_o && bus_oe_o == ALL_ON)); // R1
    AST_MIDCYCLE_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_oe_o == ALL_ON && !cycle_end_i) |=> bus_oe_o == ALL_ON); // R2
    AST_TAKE_RELEASES: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_oe_o == ALL_ON && bus_req_i && cycle_end_i) |=> (bus_oe_o == '0 && !bus_grant_o && exec_stall_o)); // R3
    AST_GRANT_AFTER_FLOAT: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_oe_o == '0 && !bus_grant_o) |=> bus_grant_o); // R4
    AST_GRANT_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_grant_o && bus_req_i) |=> (bus_grant_o && exec_stall_o)); // R5
    AST_RETURN_CLEAN: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_grant_o && !bus_req_i) |=> (!bus_grant_o && !exec_stall_o && bus_oe_o == ALL_ON)); // R6
    AST_IRQ_BLOCKED: assert property (@(posedge clk_i)
        irq_accept_o |-> (!bus_req_i && !rst_i && bus_oe_o == ALL_ON)); // R8
    AST_GRANT_FLOATS: assert property (@(posedge clk_i)
        bus_grant_o |-> bus_oe_o == '0); // R9
    AST_GROUPS_MATCH: assert property (@(posedge clk_i)
        (bus_oe_o == '0) || (bus_oe_o == ALL_ON)); // R10
endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk #(.GROUPS(bha_pkg::BUS_GROUPS)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .bus_req_i    (bus_req_i),
    .cycle_end_i  (cycle_end_i),
    .bus_grant_o  (bus_grant_o),
    .exec_stall_o (exec_stall_o),
    .irq_accept_o (irq_accept_o),
    .bus_oe_o     (bus_oe_o)
);

// File: tb/bus_hold_arbiter_tb_top.sv
module bus_hold_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    logic clk = 1'b0;
    logic rst, req, cyc, intr, insn;
    logic grant, stall, acc;
    logic [2:0] oe;
    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_hold_arbiter dut_i (
        .clk_i(clk), .rst_i(rst), .bus_req_i(req), .cycle_end_i(cyc),
        .intr_i(intr), .insn_end_i(insn), .bus_grant_o(grant),
        .exec_stall_o(stall), .irq_accept_o(acc), .bus_oe_o(oe)
    );

    // {req, cyc, intr, insn, exp_oe[2:0], exp_grant, exp_stall, exp_acc}
    localparam logic [9:0] VEC [NVEC] = '{
        10'b0011_111_001, // R7 accept at boundary while owned
        10'b1011_111_000, // R8 pending request blocks interrupt; R2 no cycle end
        10'b1000_111_000, // R2 still owned mid-cycle
        10'b1100_111_000, // take at cycle end
        10'b1011_000_010, // R3 released, no grant yet; R8
        10'b1000_000_110, // R4 grant one clock later
        10'b0011_000_110, // R5 grant held; R8 blocked during grant
        10'b0011_111_001, // R6 clean return; R7 accept
        10'b0100_111_000, // cycle end without request
        10'b0010_111_000, // R7 no boundary, no accept
        10'b1100_111_000, // take again
        10'b0000_000_010, // R4 request dropped during release
        10'b0000_000_110, // R4 grant still given for one cycle
        10'b0000_111_000  // R6 back to owned
    };

    task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic r, input logic q, input logic c, input logic i, input logic n);
        @(negedge clk);
        rst = r; req = q; cyc = c; intr = i; insn = n;
        #1;
    endtask

    initial begin
        rst = 1'b1; req = 1'b0; cyc = 1'b0; intr = 1'b0; insn = 1'b0;
        repeat (2) @(posedge clk);
        // R1 reset state
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R1 oe", oe, 3'b111);
        check("R1 grant/stall/acc", {grant, stall, acc}, 3'b000);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 after release of reset", {grant, stall, acc}, 3'b000);

        for (int k = 0; k < NVEC; k++) begin
            drive(1'b0, VEC[k][9], VEC[k][8], VEC[k][7], VEC[k][6]);
            check($sformatf("vec%0d R10 oe", k), oe, VEC[k][5:3]);
            check($sformatf("vec%0d grant/stall/acc", k), {grant, stall, acc}, VEC[k][2:0]);
        end

        // R1 reset in the middle of a grant clears it in the same cycle
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 granted before reset", {grant, stall, acc}, 3'b110);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R1 grant dropped by reset", {grant, stall, acc}, 3'b000);
        check("R1 drivers on under reset", oe, 3'b111);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R1 reset outranks request", {grant, stall, acc}, 3'b000);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R7 owned after reset", {grant, stall, acc}, 3'b001);
        check("R9 oe owned", oe, 3'b111);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule